// File: doc/BRIEF.md
# Byte-Memory Pattern Self-Test Controller

This controller drives a byte-wide nonvolatile memory through a request/ready/error handshake. It can measure how much of the memory holds data and report that as a percentage. It keeps a sticky flag that records past write failures. It runs a destructive two-pattern write-and-verify test and erases the whole array at the end. A second command erases the array without testing it. Both the test and the erase wait for an operator to confirm with a SET key. While the block waits, a prompt output alternates at a fixed interval.

A test command first reads every location. A location counts as occupied when its value differs from the erased value 8'hFF. The controller rounds the occupied fraction up to a multiple of ten percent, using sequential subtraction instead of a divider. It then raises the confirmation prompt. After SET, it writes the address low byte to every location and reads the array back. It then writes the inverse of that byte to every location and reads it back again. Finally it writes 8'hFF to every location. The first error ends the run and goes straight to the result. The serial link to the physical memory sits outside the block.

Top module: `nvm_selftest`

## Requirements
- R1: After reset, busy, mem_req, occ_valid, res_valid, prompt_on, prompt_alt and missed are all 0.
- R2: A test command first reads addresses 0 to DEPTH-1 in ascending order. It counts the locations whose value is not 8'hFF and sets occ_valid with occ_pct. occ_pct is 0 when that count is zero. Otherwise it is 10*ceil(count*10/DEPTH), so it is always a multiple of 10 and never above 100.
- R3: In the confirmation wait, prompt_on is 1 and prompt_alt inverts every BLINK_CYCLES cycles. The block makes no memory transfer until key_set is sampled high.
- R4: Pass one writes data equal to the address low byte at each address in ascending order. It then reads every address in ascending order, and a read that does not match that byte is an error.
- R5: Pass two writes the bitwise inverse of the address low byte at each address in ascending order. It then reads every address and compares each byte against that inverse.
- R6: After both passes, the test writes 8'hFF to every address in ascending order.
- R7: A transfer is an error when mem_err is high with mem_ready, or when a check read returns a mismatching byte. After an error, the block issues no further transfer, and the run ends with res_good = 0.
- R8: `missed` goes to 1 on any write that completes with mem_err. It returns to 0 only when a full erase sweep completes without error. Read errors leave it unchanged.
- R9: An erase command raises the same confirmation prompt. After key_set it writes 8'hFF to every address in ascending order and reports res_good = 1, or 0 on error, without reading.
- R10: At the end of every run, busy falls and res_valid rises on the same clock edge. res_good is 1 exactly when the run saw no error.
- R11: While mem_req is high and mem_ready is low, mem_req, mem_addr, mem_we and mem_wdata stay unchanged.
- R12: cmd_test and cmd_erase have no effect while a run is in progress, and key_set has no effect outside the confirmation wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_test | input | 1 | Start occupancy scan plus pattern test (pulse) |
| cmd_erase | input | 1 | Start erase-only run (pulse) |
| key_set | input | 1 | Confirmation key |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Transfer accepted this cycle |
| mem_err | input | 1 | Transfer failed, valid with mem_ready |
| busy | output | 1 | A run is in progress |
| prompt_on | output | 1 | Confirmation wait active |
| prompt_alt | output | 1 | Alternating prompt phase |
| occ_valid | output | 1 | occ_pct holds the latest scan result |
| occ_pct | output | 7 | Occupancy in percent, multiple of 10 |
| res_valid | output | 1 | Result of the last run is available |
| res_good | output | 1 | 1 = run passed, 0 = error |
| missed | output | 1 | Sticky write-error history flag |

## Verification
The assertions assume the memory answers in the same cycle it raises mem_ready, with read data valid in that cycle. They also assume mem_err is meaningful only when it comes with mem_ready on an active request. The bench models the memory as a behavioural byte array that raises mem_ready on a random three cycles in four. It applies read corruption or mem_err only on one chosen accepted transfer, and it drives commands and key_set as one-cycle pulses. Each accepted transfer is checked against the address, direction and data that the requirements predict for its position in the run.

// File: rtl/nvm_st_pkg.sv
package nvm_st_pkg;
  typedef enum logic [3:0] {
    PH_IDLE = 4'd0,
    PH_SCAN = 4'd1,
    PH_DIV  = 4'd2,
    PH_CONF = 4'd3,
    PH_WR1  = 4'd4,
    PH_RD1  = 4'd5,
    PH_WR2  = 4'd6,
    PH_RD2  = 4'd7,
    PH_ERS  = 4'd8,
    PH_DONE = 4'd9
  } phase_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
  localparam int PCT_STEP = 10;
endpackage

// File: rtl/nvm_st_pctdiv.sv
module nvm_st_pctdiv #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] count,
  output logic          done,
  output logic [6:0]    pct
);
  localparam int RW = CW + 4;

  logic [RW-1:0] rem_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
      pct   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= RW'(count) * RW'(nvm_st_pkg::PCT_STEP);
        pct   <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (rem_q == '0) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else if (rem_q > RW'(DEPTH)) begin
          rem_q <= rem_q - RW'(DEPTH);
          pct   <= pct + 7'(nvm_st_pkg::PCT_STEP);
        end else begin
          rem_q <= '0;
          pct   <= pct + 7'(nvm_st_pkg::PCT_STEP);
        end
      end
    end
  end

  // R2: finished quotient is a tens step no larger than 100
  p_pct_range_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (pct <= 7'd100) && ((pct % 7'd10) == 7'd0));
endmodule

// File: rtl/nvm_st_blink.sv
module nvm_st_blink #(
  parameter int PERIOD = 200_000_000,
  localparam int CTW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic alt
);
  logic [CTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      alt   <= 1'b0;
    end else if (cnt_q == CTW'(PERIOD - 1)) begin
      cnt_q <= '0;
      alt   <= ~alt;
    end else begin
      cnt_q <= cnt_q + CTW'(1);
    end
  end

  // R3: the alternating phase exists only while the prompt is shown
  p_alt_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> !alt);
endmodule

// File: rtl/nvm_selftest.sv
module nvm_selftest #(
  parameter int DEPTH        = 256,
  parameter int BLINK_CYCLES = 200_000_000,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_test,
  input  logic          cmd_erase,
  input  logic          key_set,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic          busy,
  output logic          prompt_on,
  output logic          prompt_alt,
  output logic          occ_valid,
  output logic [6:0]    occ_pct,
  output logic          res_valid,
  output logic          res_good,
  output logic          missed
);
  import nvm_st_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = (AW < 8) ? AW : 8;

  phase_t        phase_q;
  logic          erase_only_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          err_q;
  logic          div_go_q;
  logic          div_done;
  logic [6:0]    div_pct;

  logic [7:0] lo_byte;
  logic [7:0] chk_byte;
  logic       is_chk;
  logic       xfer;
  logic       bad;
  logic       last;
  phase_t     after_sweep;

  always_comb begin
    lo_byte = '0;
    lo_byte[LW-1:0] = addr_q[LW-1:0];
  end

  assign mem_req  = (phase_q == PH_SCAN) || (phase_q == PH_WR1) || (phase_q == PH_RD1) ||
                    (phase_q == PH_WR2) || (phase_q == PH_RD2) || (phase_q == PH_ERS);
  assign mem_we   = (phase_q == PH_WR1) || (phase_q == PH_WR2) || (phase_q == PH_ERS);
  assign mem_addr = addr_q;

  always_comb begin
    case (phase_q)
      PH_WR1:  mem_wdata = lo_byte;
      PH_WR2:  mem_wdata = ~lo_byte;
      PH_ERS:  mem_wdata = ERASED_BYTE;
      default: mem_wdata = 8'h00;
    endcase
  end

  assign is_chk   = (phase_q == PH_RD1) || (phase_q == PH_RD2);
  assign chk_byte = (phase_q == PH_RD1) ? lo_byte : ~lo_byte;
  assign xfer     = mem_req && mem_ready;
  assign bad      = mem_err || (is_chk && (mem_rdata != chk_byte));
  assign last     = (addr_q == AW'(DEPTH - 1));

  always_comb begin
    case (phase_q)
      PH_SCAN: after_sweep = PH_DIV;
      PH_WR1:  after_sweep = PH_RD1;
      PH_RD1:  after_sweep = PH_WR2;
      PH_WR2:  after_sweep = PH_RD2;
      PH_RD2:  after_sweep = PH_ERS;
      default: after_sweep = PH_DONE;
    endcase
  end

  nvm_st_pctdiv #(.DEPTH(DEPTH)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_go_q),
    .count (cnt_q),
    .done  (div_done),
    .pct   (div_pct)
  );

  nvm_st_blink #(.PERIOD(BLINK_CYCLES)) u_blink (
    .clk (clk),
    .rst (rst),
    .en  (prompt_on),
    .alt (prompt_alt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_IDLE;
      erase_only_q <= 1'b0;
      addr_q       <= '0;
      cnt_q        <= '0;
      err_q        <= 1'b0;
      div_go_q     <= 1'b0;
      busy         <= 1'b0;
      prompt_on    <= 1'b0;
      occ_valid    <= 1'b0;
      occ_pct      <= '0;
      res_valid    <= 1'b0;
      res_good     <= 1'b0;
      missed       <= 1'b0;
    end else begin
      div_go_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (cmd_test || cmd_erase) begin
            busy         <= 1'b1;
            erase_only_q <= !cmd_test;
            addr_q       <= '0;
            cnt_q        <= '0;
            err_q        <= 1'b0;
            res_valid    <= 1'b0;
            occ_valid    <= 1'b0;
            if (cmd_test) begin
              phase_q <= PH_SCAN;
            end else begin
              phase_q   <= PH_CONF;
              prompt_on <= 1'b1;
            end
          end
        end
        PH_DIV: begin
          if (div_done) begin
            occ_pct   <= div_pct;
            occ_valid <= 1'b1;
            prompt_on <= 1'b1;
            phase_q   <= PH_CONF;
          end
        end
        PH_CONF: begin
          if (key_set) begin
            prompt_on <= 1'b0;
            phase_q   <= erase_only_q ? PH_ERS : PH_WR1;
          end
        end
        PH_DONE: begin
          res_valid <= 1'b1;
          res_good  <= !err_q;
          busy      <= 1'b0;
          phase_q   <= PH_IDLE;
        end
        default: begin
          if (xfer) begin
            if (bad && (phase_q != PH_SCAN || mem_err)) begin
              err_q   <= 1'b1;
              phase_q <= PH_DONE;
              if (mem_we && mem_err) missed <= 1'b1;
            end else begin
              if (phase_q == PH_SCAN && mem_rdata != ERASED_BYTE) cnt_q <= cnt_q + CW'(1);
              if (last) begin
                addr_q  <= '0;
                phase_q <= after_sweep;
                if (phase_q == PH_SCAN) div_go_q <= 1'b1;
                if (phase_q == PH_ERS) missed <= 1'b0;
              end else begin
                addr_q <= addr_q + AW'(1);
              end
            end
          end
        end
      endcase
    end
  end

  // R11: a stalled request keeps its address, direction and data
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7: a failed transfer is the last one of the run
  p_err_stops_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && mem_err) |=> !mem_req);

  // R10: the run ends with a result on the same edge
  p_done_with_result_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> res_valid);

  // R8: history clears only when an erase sweep has just completed
  p_missed_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(missed) |-> (phase_q == PH_DONE) && !err_q);

  // R3: no memory traffic while the confirmation prompt is shown
  p_quiet_prompt_r3: assert property (@(posedge clk) disable iff (rst)
    prompt_on |-> !mem_req);
endmodule

// File: tb/nvm_selftest_tb_top.sv
`timescale 1ns/1ps
module nvm_selftest_tb_top;
  localparam int D  = 16;
  localparam int BL = 4;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_test = 1'b0, cmd_erase = 1'b0, key_set = 1'b0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic mem_ready = 1'b0, mem_err = 1'b0;
  logic busy, prompt_on, prompt_alt, occ_valid, res_valid, res_good, missed;
  logic [6:0] occ_pct;

  logic [7:0] mem [D];
  logic corrupt = 1'b0;

  int tests = 0, fails = 0;
  int idx = 0, run_total = 0, fail_at = -1;
  bit fail_corrupt = 0, run_ers = 0, active = 0, finished = 0;
  bit hist = 0;
  bit stall_prev = 0, prev_we = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [7:0] prev_wd = '0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr] ^ {7'd0, corrupt};

  nvm_selftest #(.DEPTH(D), .BLINK_CYCLES(BL)) dut_i (
    .clk(clk), .rst(rst), .cmd_test(cmd_test), .cmd_erase(cmd_erase), .key_set(key_set),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err),
    .busy(busy), .prompt_on(prompt_on), .prompt_alt(prompt_alt), .occ_valid(occ_valid),
    .occ_pct(occ_pct), .res_valid(res_valid), .res_good(res_good), .missed(missed));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_op(input int i, input bit ers);
    int ph;
    logic [7:0] lo;
    if (ers) return {1'b1, 8'(i), 8'hFF};
    ph = i / D;
    lo = 8'(i % D);
    case (ph)
      1:       return {1'b1, lo, lo};
      3:       return {1'b1, lo, ~lo};
      5:       return {1'b1, lo, 8'hFF};
      default: return {1'b0, lo, 8'h00};
    endcase
  endfunction

  function automatic string op_tag(input int i, input bit ers);
    if (ers) return "R9";
    case (i / D)
      0: return "R2";
      1, 2: return "R4";
      3, 4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Reference memory and per-transfer comparison, evaluated every cycle
  always @(negedge clk) begin
    logic [16:0] e;
    bit rdy;
    if (!rst) begin
      if (stall_prev)
        chk(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wd,
            "R11 stalled request changed", int'(mem_addr), int'(prev_addr));
      rdy = ($urandom % 4) != 0;
      mem_ready = rdy;
      mem_err = 1'b0;
      corrupt = 1'b0;
      if (mem_req && rdy) begin
        if (!active || idx >= run_total) begin
          chk(1'b0, "R12 unexpected transfer", idx, run_total);
        end else begin
          e = exp_op(idx, run_ers);
          chk(mem_we == e[16] && 8'(mem_addr) == e[15:8] && (!e[16] || mem_wdata == e[7:0]),
              op_tag(idx, run_ers), int'({mem_we, 8'(mem_addr), mem_wdata}), int'(e));
        end
        if (idx == fail_at) begin
          if (fail_corrupt) corrupt = 1'b1; else mem_err = 1'b1;
        end
        if (mem_we && !mem_err) mem[mem_addr] = mem_wdata;
        idx++;
      end
      stall_prev = mem_req && !rdy;
      prev_addr = mem_addr;
      prev_we = mem_we;
      prev_wd = mem_wdata;
    end
  end

  task automatic pulse_cmd(input int which);
    @(negedge clk);
    if (which == 0) cmd_test = 1'b1;
    else if (which == 1) cmd_erase = 1'b1;
    else key_set = 1'b1;
    @(negedge clk);
    cmd_test = 1'b0; cmd_erase = 1'b0; key_set = 1'b0;
  endtask

  task automatic run(input bit ers, input int used, input int f_at, input bit f_corrupt);
    int exp_pct, c0, flips, exp_total;
    bit last_alt, exp_hist, fail_is_wr;
    for (int i = 0; i < D; i++) mem[i] = (i < used) ? 8'(i * 3) : 8'hFF;
    exp_pct = (used == 0) ? 0 : 10 * ((used * 10 + D - 1) / D);
    exp_total = (f_at >= 0) ? f_at + 1 : (ers ? D : 6 * D);
    fail_is_wr = (f_at >= 0) && exp_op(f_at, ers)[16] && !f_corrupt;
    exp_hist = fail_is_wr ? 1'b1 : ((f_at < 0) ? 1'b0 : hist);
    idx = 0; run_total = exp_total; fail_at = f_at; fail_corrupt = f_corrupt;
    run_ers = ers; active = 1;
    pulse_cmd(ers ? 1 : 0);
    // R12: a second command while busy must not disturb the run
    pulse_cmd(ers ? 0 : 1);
    if (!ers) begin
      while (!occ_valid) @(negedge clk);
      chk(occ_pct == 7'(exp_pct), "R2 occupancy", int'(occ_pct), exp_pct);
    end
    while (!prompt_on) @(negedge clk);
    c0 = idx; flips = 0; last_alt = prompt_alt;
    for (int k = 0; k < 3 * BL; k++) begin
      @(negedge clk);
      if (prompt_alt != last_alt) flips++;
      last_alt = prompt_alt;
    end
    chk(flips >= 2, "R3 prompt alternation", flips, 2);
    chk(idx == c0 && busy, "R3 no transfer before SET", idx, c0);
    pulse_cmd(2);
    while (!res_valid) @(negedge clk);
    chk(!busy, "R10 busy cleared", int'(busy), 0);
    chk(res_good == (f_at < 0), (f_at < 0) ? "R10 result good" : "R7 result error",
        int'(res_good), int'(f_at < 0));
    chk(idx == exp_total, "R7 transfer count", idx, exp_total);
    chk(missed == exp_hist, "R8 history flag", int'(missed), int'(exp_hist));
    hist = exp_hist;
    if (f_at < 0)
      for (int i = 0; i < D; i++)
        chk(mem[i] == 8'hFF, ers ? "R9 erased" : "R6 erased", int'(mem[i]), 255);
    active = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req && !occ_valid && !res_valid && !prompt_on && !prompt_alt && !missed,
        "R1 reset state", int'({busy, mem_req, occ_valid, res_valid, prompt_on, prompt_alt, missed}), 0);
    // R12 key_set while idle has no effect
    pulse_cmd(2);
    repeat (4) @(negedge clk);
    chk(!busy && !prompt_on && idx == 0, "R12 key_set ignored in idle", int'(busy), 0);

    run(0, 1, -1, 0);          // 10 percent, good
    run(0, D, -1, 0);          // 100 percent
    run(0, 9, D + 3, 0);       // write error in pass one: history set
    run(0, 0, 4 * D + 2, 1);   // corrupt check read in pass two: history kept
    run(0, 8, 2 * D + 5, 1);   // corrupt check read in pass one
    run(1, 3, 5, 0);           // erase-only with write error
    run(1, 5, -1, 0);          // erase-only good: history cleared
    run(0, 0, -1, 0);          // 0 percent
    run(0, 9, -1, 0);          // 60 percent

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule